// File: doc/BRIEF.md
# Clock stop and power-down gating controller

This block sits between a clock generator's synthesized clocks and the pins that carry them. It gates a group of CPU-rate clock outputs and a group of PCI-rate clock outputs in response to three active-low requests: stop the CPU group, stop the PCI group, and power the whole generator down. The requests may change at any time with respect to any clock. The block brings them into the domain of a free-running PCI-rate clock, which also serves as its timebase, and every latency is counted in rising edges of that clock.

A stopped output is held low and never produces a shortened pulse: each output has its own enable flop that updates on the falling edge of the clock it gates. Power-down removes all output enables first. One cycle later it drops the enable for the oscillator and VCOs. On release the oscillator enable returns at once, but the outputs stay low until a lock-time counter reaches its terminal count. That counter stands in for the PLL settling time, about 3 ms on real hardware. The CPU source may run at either of its selectable rates (100 or 66 MHz class), and the block passes that rate through unchanged.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, every clock output and `osc_en` are low. After reset is released with `pwr_down_n` high, the sequence is the one in R6.
- R2: While the synchronized `cpu_stop_n` is low, every bit of `cpu_clk_out` stays low. `pci_clk_out` and `pci_free_out` keep toggling.
- R3: While the synchronized `pci_stop_n` is low, every bit of `pci_clk_out` stays low. `cpu_clk_out` and `pci_free_out` keep toggling.
- R4: Take an edge of `cpu_stop_n` or `pci_stop_n` placed between two rising edges of `clk_pci_free`. It is in full effect on the affected group, in either direction, by the SYNC_STAGES+2-th following rising edge of `clk_pci_free`.
- R5: After `pwr_down_n` falls, `osc_en` is still high at the SYNC_STAGES+2-th rising edge of `clk_pci_free`. By the SYNC_STAGES+3-th edge, `osc_en` and every clock output, `pci_free_out` included, are low. `osc_en` falls only after all output enable requests have already been removed.
- R6: After `pwr_down_n` rises, `osc_en` is high by the SYNC_STAGES+1-th rising edge of `clk_pci_free`. All outputs stay low through edge SYNC_STAGES+LOCK_CYCLES+1 and run from edge SYNC_STAGES+LOCK_CYCLES+3. The output groups are released only once the lock counter has reached LOCK_CYCLES-1.
- R7: A running output group reproduces its source clock cycle for cycle, at whichever CPU source period is applied (a 10 ns and a 15 ns period are both used).
- R8: Every high pulse on a gated output begins on a rising edge of its source and ends on the next falling edge of that source. No pulse is ever shortened.
- R9: A power-down pulse as short as one `clk_pci_free` period still completes the full shutdown. `osc_en` is low after edge SYNC_STAGES+3, and the full lock wait of R6 follows.
- R10: Power-down dominates the stop requests. After a power-up with `cpu_stop_n` held low, the CPU group stays low while the PCI groups run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pci_free | input | 1 | Free-running PCI-rate clock; control timebase and source of `pci_free_out` |
| rst_n | input | 1 | Synchronous active-low reset in the `clk_pci_free` domain |
| clk_cpu_src | input | 1 | Ungated CPU clock from the synthesizer |
| clk_pci_src | input | 1 | Ungated PCI clock from the synthesizer |
| cpu_stop_n | input | 1 | Asynchronous, low stops the CPU group |
| pci_stop_n | input | 1 | Asynchronous, low stops the gated PCI group |
| pwr_down_n | input | 1 | Asynchronous, low powers the generator down |
| cpu_clk_out | output | N_CPU | Gated CPU clock outputs |
| pci_clk_out | output | N_PCI | Gated PCI clock outputs |
| pci_free_out | output | 1 | PCI output that ignores PCI stop and is low only in power-down |
| osc_en | output | 1 | Enable for the crystal oscillator and the VCOs |

## Verification
Assertions check the control path on every cycle. A stop request clears its group's enable request on the next edge. A synchronized power-down clears all requests within two edges. `osc_en` never falls while a request is still set. The outputs are never released before the lock counter reaches its last value, and that counter never passes its bound. Only the bench can show the clock-level effects: outputs held low or toggling at the pins, the exact edge bounds of the latencies, pulses that start and end on source edges at both CPU periods, and the order of shutdown after a one-cycle power-down pulse.

// File: rtl/clk_stop_gate_pkg.sv
// Shared types for the clock stop and power-down gating controller.
// Assumes: nothing beyond the standard language.
package clk_stop_gate_pkg;

    // Power sequencer states; order matters only for readability.
    typedef enum logic [2:0] {
        PS_OFF   = 3'd0,   // oscillator and VCOs disabled
        PS_LOCK  = 3'd1,   // oscillator on, waiting for lock time
        PS_RUN   = 3'd2,   // outputs may run
        PS_DRAIN = 3'd3,   // output requests withdrawn
        PS_HALT  = 3'd4    // outputs gated, oscillator still on for one cycle
    } pwr_state_e;

endpackage

// File: rtl/clk_stop_gate_sync.sv
// Multi-stage level synchronizer for one asynchronous control input.
// Assumes: d_async is a level that stays stable for at least one clock
// period; the reset value is what the input is taken to be during reset.
module clk_stop_gate_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    generate
        if (STAGES <= 1) begin : g_single
            logic flop_q;
            // Single capture flop when only one stage is requested.
            always_ff @(posedge clk) begin
                if (!rst_n) flop_q <= RST_VAL;
                else        flop_q <= d_async;
            end
            assign q_sync = flop_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Shift the input through the chain of capture flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
            assign q_sync = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/clk_stop_gate_pwr_seq.sv
// Power-down / power-up sequencer. It withdraws the output requests, then
// drops the oscillator enable, and on release waits LOCK_CYCLES timebase
// cycles before it lets the outputs run.
// Assumes: pd_ok is already synchronized to clk (high = normal operation);
// clk keeps running during power-down because it is the timebase model.
module clk_stop_gate_pwr_seq
    import clk_stop_gate_pkg::*;
#(
    parameter int LOCK_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_ok,
    output logic run_o,
    output logic osc_en_o
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

    pwr_state_e       state_q, state_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, osc_q;

    // Next-state decision for the power sequence.
    always_comb begin
        state_nxt = state_q;
        case (state_q)
            PS_OFF:   state_nxt = pd_ok ? PS_LOCK : PS_OFF;
            PS_LOCK: begin
                if (!pd_ok)                state_nxt = PS_OFF;
                else if (cnt_q == CNT_LAST) state_nxt = PS_RUN;
                else                       state_nxt = PS_LOCK;
            end
            PS_RUN:   state_nxt = pd_ok ? PS_RUN : PS_DRAIN;
            PS_DRAIN: state_nxt = PS_HALT;
            PS_HALT:  state_nxt = PS_OFF;
            default:  state_nxt = PS_OFF;
        endcase
    end

    // State register; reset leaves the generator powered down.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_OFF;
        else        state_q <= state_nxt;
    end

    // Lock-time counter: counts while staying in LOCK, clears otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (state_q == PS_LOCK && state_nxt == PS_LOCK)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    // Registered outputs decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            osc_q <= 1'b0;
        end else begin
            run_q <= (state_nxt == PS_RUN);
            osc_q <= (state_nxt != PS_OFF);
        end
    end

    assign run_o    = run_q;
    assign osc_en_o = osc_q;

    // R6: outputs are released only after the full lock count.
    a_r6_run_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> ($past(cnt_q) == CNT_LAST && $past(state_q) == PS_LOCK));

    // R6: the lock counter never runs past its terminal value.
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    // R9: once draining starts, shutdown reaches OFF even if pd_ok returns.
    a_r9_drain_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DRAIN) |=> ##1 !osc_q);

endmodule

// File: rtl/clk_stop_gate_cell.sv
// Glitch-free gate for one clock output. The enable is captured on the
// falling edge of the gated clock, so it only changes while the clock is
// low and every passed pulse is a full source pulse.
// Assumes: en_req is stable around falling edges of clk_src (it comes from
// a register in a related clock domain).
module clk_stop_gate_cell (
    input  logic clk_src,
    input  logic rst_n,
    input  logic en_req,
    output logic clk_o
);

    logic en_q;

    // Capture the enable while the source clock is low.
    always_ff @(negedge clk_src) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_req;
    end

    assign clk_o = clk_src & en_q;

endmodule

// File: rtl/clk_stop_gate.sv
// Clock stop and power-down gating controller (top).
// Synchronizes the three active-low requests to the free-running PCI clock,
// runs the power sequencer, registers one enable request per output group
// and gates every output through its own falling-edge enable cell.
// Assumes: clk_pci_free runs continuously; clk_cpu_src and clk_pci_src run
// whenever the block is out of reset.
module clk_stop_gate #(
    parameter int N_CPU       = 2,
    parameter int N_PCI       = 5,
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_CYCLES = 100000
) (
    input  logic             clk_pci_free,
    input  logic             rst_n,
    input  logic             clk_cpu_src,
    input  logic             clk_pci_src,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_down_n,
    output logic [N_CPU-1:0] cpu_clk_out,
    output logic [N_PCI-1:0] pci_clk_out,
    output logic             pci_free_out,
    output logic             osc_en
);

    logic cpu_ok, pci_ok, pd_ok;
    logic run;
    logic cpu_req_q, pci_req_q, free_req_q;

    clk_stop_gate_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cpu (
        .clk(clk_pci_free), .rst_n(rst_n), .d_async(cpu_stop_n), .q_sync(cpu_ok));

    clk_stop_gate_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pci (
        .clk(clk_pci_free), .rst_n(rst_n), .d_async(pci_stop_n), .q_sync(pci_ok));

    clk_stop_gate_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pd (
        .clk(clk_pci_free), .rst_n(rst_n), .d_async(pwr_down_n), .q_sync(pd_ok));

    clk_stop_gate_pwr_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_pwr_seq (
        .clk(clk_pci_free), .rst_n(rst_n), .pd_ok(pd_ok),
        .run_o(run), .osc_en_o(osc_en));

    // Per-group enable requests: running state combined with each stop.
    always_ff @(posedge clk_pci_free) begin
        if (!rst_n) begin
            cpu_req_q  <= 1'b0;
            pci_req_q  <= 1'b0;
            free_req_q <= 1'b0;
        end else begin
            cpu_req_q  <= run & cpu_ok;
            pci_req_q  <= run & pci_ok;
            free_req_q <= run;
        end
    end

    // One gate cell per CPU output.
    genvar gi;
    generate
        for (gi = 0; gi < N_CPU; gi++) begin : g_cpu
            clk_stop_gate_cell u_cell (
                .clk_src(clk_cpu_src), .rst_n(rst_n),
                .en_req(cpu_req_q), .clk_o(cpu_clk_out[gi]));
        end
        for (gi = 0; gi < N_PCI; gi++) begin : g_pci
            clk_stop_gate_cell u_cell (
                .clk_src(clk_pci_src), .rst_n(rst_n),
                .en_req(pci_req_q), .clk_o(pci_clk_out[gi]));
        end
    endgenerate

    // Free-running PCI output: gated only by power state.
    clk_stop_gate_cell u_free_cell (
        .clk_src(clk_pci_free), .rst_n(rst_n),
        .en_req(free_req_q), .clk_o(pci_free_out));

    // R2: a synchronized CPU stop withdraws the CPU request next cycle.
    a_r2_cpu_stop_req: assert property (@(posedge clk_pci_free) disable iff (!rst_n)
        !cpu_ok |=> !cpu_req_q);

    // R3: a synchronized PCI stop withdraws the PCI request next cycle.
    a_r3_pci_stop_req: assert property (@(posedge clk_pci_free) disable iff (!rst_n)
        !pci_ok |=> !pci_req_q);

    // R5: power-down clears every request within two cycles.
    a_r5_pd_clears_req: assert property (@(posedge clk_pci_free) disable iff (!rst_n)
        !pd_ok |-> ##2 (!cpu_req_q && !pci_req_q && !free_req_q));

    // R5: the oscillator enable falls only after all requests are gone.
    a_r5_osc_after_gate: assert property (@(posedge clk_pci_free) disable iff (!rst_n)
        $fell(osc_en) |-> $past(!cpu_req_q && !pci_req_q && !free_req_q));

    // R10: while powered down no group may be requested.
    a_r10_pd_dominates: assert property (@(posedge clk_pci_free) disable iff (!rst_n)
        !osc_en |-> (!cpu_req_q && !pci_req_q && !free_req_q));

endmodule

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
module test_clk_stop_gate;

    localparam int N_CPU = 2;
    localparam int N_PCI = 5;
    localparam int SYNC  = 2;
    localparam int LOCK  = 16;

    logic clk_free = 1'b0;
    logic cpu_src  = 1'b0;
    logic pci_src;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_down_n = 1'b1;
    logic [N_CPU-1:0] cpu_clk_out;
    logic [N_PCI-1:0] pci_clk_out;
    logic pci_free_out, osc_en;

    realtime cpu_half = 5.0;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #10 clk_free = ~clk_free;           // 50 MHz timebase
    always #(cpu_half) cpu_src = ~cpu_src;     // selectable CPU rate
    assign pci_src = clk_free;

    clk_stop_gate #(.N_CPU(N_CPU), .N_PCI(N_PCI), .SYNC_STAGES(SYNC), .LOCK_CYCLES(LOCK))
    i_clk_stop_gate (
        .clk_pci_free(clk_free), .rst_n(rst_n), .clk_cpu_src(cpu_src),
        .clk_pci_src(pci_src), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .pwr_down_n(pwr_down_n), .cpu_clk_out(cpu_clk_out), .pci_clk_out(pci_clk_out),
        .pci_free_out(pci_free_out), .osc_en(osc_en));

    // Window samplers: mid-high level of each group while a window is open.
    bit win_on = 1'b0;
    int cpu_n, cpu_hi, cpu_lo, pci_n, pci_hi, pci_lo, fr_n, fr_hi, fr_lo;

    always @(posedge cpu_src) if (win_on) begin
        #1;
        cpu_n++;
        if (cpu_clk_out == '1) cpu_hi++;
        else if (cpu_clk_out == '0) cpu_lo++;
    end

    always @(posedge clk_free) if (win_on) begin
        #1;
        pci_n++; fr_n++;
        if (pci_clk_out == '1) pci_hi++;
        else if (pci_clk_out == '0) pci_lo++;
        if (pci_free_out) fr_hi++; else fr_lo++;
    end

    // Pulse-shape monitors for R8.
    realtime t_cs_rise, t_co_rise, t_ps_rise, t_po_rise;
    int runt = 0, pulses = 0;
    always @(posedge cpu_src)        t_cs_rise = $realtime;
    always @(posedge cpu_clk_out[0]) t_co_rise = $realtime;
    always @(posedge pci_src)        t_ps_rise = $realtime;
    always @(posedge pci_clk_out[0]) t_po_rise = $realtime;
    always @(negedge cpu_clk_out[0]) if (rst_n) begin
        #0.1; pulses++;
        if (t_co_rise != t_cs_rise || cpu_src !== 1'b0) runt++;
    end
    always @(negedge pci_clk_out[0]) if (rst_n) begin
        #0.1; pulses++;
        if (t_po_rise != t_ps_rise || pci_src !== 1'b0) runt++;
    end

    // Expected-run functions derived from the requirements.
    function automatic bit exp_cpu(bit cs, bit pd); return cs & pd; endfunction
    function automatic bit exp_pci(bit ps, bit pd); return ps & pd; endfunction
    function automatic bit exp_free(bit pd);        return pd;      endfunction

    task automatic chk(string req, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic chk_grp(string req, string what, int n, int hi, int lo, bit run);
        chk(req, {what, " sampled"}, int'(n > 0), 1);
        if (run) chk(req, {what, " running samples"}, hi, n);
        else     chk(req, {what, " low samples"}, lo, n);
    endtask

    // Call right after a falling edge of clk_free.
    task automatic run_window(int edges);
        cpu_n = 0; cpu_hi = 0; cpu_lo = 0;
        pci_n = 0; pci_hi = 0; pci_lo = 0;
        fr_n = 0; fr_hi = 0; fr_lo = 0;
        win_on = 1'b1;
        repeat (edges) @(posedge clk_free);
        @(negedge clk_free);
        win_on = 1'b0;
        #2;
    endtask

    task automatic chk_all(string req, bit c, bit p, bit f);
        chk_grp(req, "cpu", cpu_n, cpu_hi, cpu_lo, c);
        chk_grp(req, "pci", pci_n, pci_hi, pci_lo, p);
        chk_grp(req, "free", fr_n, fr_hi, fr_lo, f);
    endtask

    // Power-up sequence timing, starting at the negedge where pd was released.
    task automatic powerup_seq(string req, bit cs, bit ps);
        repeat (SYNC + 1) @(posedge clk_free);
        @(negedge clk_free);
        chk(req, "osc_en after release", int'(osc_en), 1);
        run_window(SYNC + LOCK - 2);
        chk_all(req, 1'b0, 1'b0, 1'b0);
        repeat (2) @(posedge clk_free);
        @(negedge clk_free);
        run_window(8);
        chk_all(req, exp_cpu(cs, 1'b1), exp_pci(ps, 1'b1), exp_free(1'b1));
    endtask

    initial begin : main
        int seed;
        seed = $urandom(32'd20240611);
        // R1: reset holds everything low.
        repeat (4) @(posedge clk_free);
        @(negedge clk_free);
        run_window(6);
        chk("R1", "osc_en in reset", int'(osc_en), 0);
        chk_all("R1", 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        powerup_seq("R1", 1'b1, 1'b1);

        // R2/R3/R4/R7: random stops at two CPU periods, checked at the bound.
        for (int i = 0; i < 30; i++) begin
            bit cs, ps;
            cs = 1'($urandom);
            ps = 1'($urandom);
            @(negedge clk_free);
            cpu_half = ($urandom % 2 == 0) ? 5.0 : 7.5;
            cpu_stop_n = cs;
            pci_stop_n = ps;
            repeat (SYNC + 2) @(posedge clk_free);
            @(negedge clk_free);
            run_window(6);
            chk_grp(cs ? "R4" : "R2", "cpu", cpu_n, cpu_hi, cpu_lo, exp_cpu(cs, 1'b1));
            chk_grp(ps ? "R4" : "R3", "pci", pci_n, pci_hi, pci_lo, exp_pci(ps, 1'b1));
            chk_grp("R7", "free", fr_n, fr_hi, fr_lo, exp_free(1'b1));
        end

        // R4 directed: stop then start each group alone at the 15 ns CPU period.
        @(negedge clk_free);
        cpu_half = 7.5; cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
        repeat (SYNC + 2) @(posedge clk_free);
        @(negedge clk_free);
        cpu_stop_n = 1'b0;
        repeat (SYNC + 2) @(posedge clk_free);
        @(negedge clk_free);
        run_window(5);
        chk_all("R2", 1'b0, 1'b1, 1'b1);
        cpu_stop_n = 1'b1;
        repeat (SYNC + 2) @(posedge clk_free);
        @(negedge clk_free);
        run_window(5);
        chk_all("R4", 1'b1, 1'b1, 1'b1);

        // R5: ordered power-down.
        cpu_half = 5.0;
        @(negedge clk_free);
        pwr_down_n = 1'b0;
        repeat (SYNC + 2) @(posedge clk_free);
        @(negedge clk_free);
        chk("R5", "osc_en still on before gating done", int'(osc_en), 1);
        @(posedge clk_free);
        @(negedge clk_free);
        chk("R5", "osc_en off", int'(osc_en), 0);
        run_window(8);
        chk_all("R5", 1'b0, 1'b0, 1'b0);

        // R10: release with CPU stop held; CPU group must stay low.
        cpu_stop_n = 1'b0;
        pwr_down_n = 1'b1;
        powerup_seq("R10", 1'b0, 1'b1);
        @(negedge clk_free);
        cpu_stop_n = 1'b1;
        repeat (SYNC + 2) @(posedge clk_free);
        @(negedge clk_free);
        run_window(5);
        chk_all("R6", 1'b1, 1'b1, 1'b1);

        // R9: one-period power-down pulse still shuts down and relocks.
        @(negedge clk_free);
        pwr_down_n = 1'b0;
        @(negedge clk_free);
        pwr_down_n = 1'b1;
        repeat (SYNC + 2) @(posedge clk_free);
        @(negedge clk_free);
        chk("R9", "osc_en low after short pulse", int'(osc_en), 0);
        run_window(LOCK);
        chk_all("R9", 1'b0, 1'b0, 1'b0);
        repeat (3) @(posedge clk_free);
        @(negedge clk_free);
        run_window(6);
        chk_all("R9", 1'b1, 1'b1, 1'b1);

        // R8: every observed pulse was whole.
        chk("R8", "pulses observed", int'(pulses > 0), 1);
        chk("R8", "runt pulses", runt, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule